// File: doc/BRIEF.md
# Flash Erase-Verify Command Sequencer

This block accepts a three-step command write sequence from a simple register bus and, once launched, checks that one or more memory blocks are fully erased. Software first writes any word inside each block it wants checked (all at the same offset within their blocks), then writes the erase-verify code into the command register, and finally writes a 1 to the buffer-empty bit of the status register to launch. The launched command sits in a one-deep buffer until the execution stage takes it, so software can prepare and launch a second command while the first is still running.

The execution stage waits through a fixed setup delay and then scans offsets 0 to WORDS-1. At each offset it reads every selected block of a behavioural array model in parallel and compares the words with the erased value (all ones). It stops at the first word that is not erased, then waits through a fixed completion delay. It then sets the complete flag, and also the blank flag when no failing word was found. The bus is a single-cycle write strobe with no back-pressure: every strobe is taken in the cycle it is presented, and strobes that arrive out of order are turned into an access error instead of being stalled. The array contents are loaded through a separate model-load port.

Top module: `blankchk_ctrl`

## Requirements
- R1: After reset the status output reads 4'b0011. Bit 0 is buffer-empty (1), bit 1 is complete (1), bit 2 is blank (0) and bit 3 is access-error (0).
- R2: A write to the array space (bus_space=1), then a command write (bus_space=0, bus_addr[0]=1) of 0x05, then a status write (bus_space=0, bus_addr[0]=0) with data bit 0 set launches the command. Buffer-empty reads 0 from the edge that takes the launch write.
- R3: Buffer-empty sets again when the execution stage takes the command: one cycle after launch when the stage is idle. A command launched while another runs is taken at the edge where the running one would complete, so complete does not rise in between.
- R4: With every selected word erased, complete rises exactly WORDS+14 clock edges after the launch edge (46 with defaults).
- R5: If every word in all selected blocks is all ones, blank is 1 when complete rises.
- R6: If the first non-erased word found is at offset k, the scan stops there. Complete rises k+15 edges after the launch edge and blank stays 0.
- R7: Array writes at the same offset in several blocks select all of them. Blocks that were not selected never affect the result.
- R8: The offset and data of the array writes do not set where the scan starts or which words are checked. Only the blocks selected matter.
- R9: A command write with no prior array write, a launch with no command, a command code other than 0x05, or an array write at a different offset from the first one sets access-error. The command is then dropped: buffer-empty and complete stay 1.
- R10: A status write with data bit 3 set clears access-error.
- R11: The launch edge clears complete and blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_space | input | 1 | 1 = array space, 0 = register space |
| bus_addr | input | BLK_W+OFF_W | Array: {block, offset}; registers: bit 0 picks status (0) or command (1) |
| bus_wdata | input | DATA_W | Write data |
| ld_we | input | 1 | Array model load strobe |
| ld_addr | input | BLK_W+OFF_W | Array model load address {block, offset} |
| ld_data | input | DATA_W | Array model load data |
| stat | output | 4 | {access-error, blank, complete, buffer-empty} |

## Verification
The bench measures completion latency edge by edge. A setup or completion delay off by one shifts the 46-edge pass time or the k+15 failure time, and the bench reports it. A failing word at offset 31, and a dirty word inside a block that is not selected, catch a scan that runs one word short or one that checks unselected blocks. A command launched while another runs checks that complete stays low at the hand-over edge and that the second command ends exactly 45 edges later. Each out-of-order sequence must raise access-error without starting a scan; a design that started anyway would drop complete.

// File: rtl/blankchk_pkg.sv
package blankchk_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_CMD} seq_e;
  typedef enum logic [1:0] {EX_IDLE, EX_SETUP, EX_SCAN, EX_DONE} ex_e;
  localparam logic [7:0] CMD_BLANK_CHECK = 8'h05;
  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_BLANK = 2;
  localparam int ST_ERR   = 3;
endpackage

// File: rtl/bc_array_model.sv
module bc_array_model #(
  parameter int NUM_BLK = 4,
  parameter int OFF_W   = 5,
  parameter int DATA_W  = 16,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int AW     = BLK_W + OFF_W,
  localparam int WORDS  = 1 << OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_we,
  input  logic [AW-1:0]      ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic [OFF_W-1:0]   rd_off,
  output logic [NUM_BLK-1:0] erased_vec
);
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic [DATA_W-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      end else if (ld_we && ld_addr[AW-1:OFF_W] == BLK_W'(b)) begin
        mem[ld_addr[OFF_W-1:0]] <= ld_data;
      end
    end
    // a word counts as erased only when every bit is one
    assign erased_vec[b] = &mem[rd_off];
  end
endmodule

// File: rtl/bc_cmd_front.sv
module bc_cmd_front
  import blankchk_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int OFF_W   = 5,
  parameter int DATA_W  = 16,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int AW     = BLK_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_space,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               take,
  output logic               buf_valid,
  output logic [NUM_BLK-1:0] buf_mask,
  output logic               launch,
  output logic               acc_err
);
  seq_e               seq_q, seq_d;
  logic [NUM_BLK-1:0] sel_q, sel_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic               abort;

  logic [BLK_W-1:0]   blk_idx;
  logic [OFF_W-1:0]   wr_off;
  logic [NUM_BLK-1:0] blk_bit;
  logic               is_arr, is_cmd, is_stat, want_launch, code_ok;

  assign blk_idx     = bus_addr[AW-1:OFF_W];
  assign wr_off      = bus_addr[OFF_W-1:0];
  assign blk_bit     = NUM_BLK'(1) << blk_idx;
  assign is_arr      = bus_wr && bus_space;
  assign is_cmd      = bus_wr && !bus_space && bus_addr[0];
  assign is_stat     = bus_wr && !bus_space && !bus_addr[0];
  assign want_launch = is_stat && bus_wdata[0];
  assign code_ok     = (bus_wdata == DATA_W'(CMD_BLANK_CHECK));

  always_comb begin
    seq_d  = seq_q;
    sel_d  = sel_q;
    off_d  = off_q;
    abort  = 1'b0;
    launch = 1'b0;
    if (!buf_valid) begin
      unique case (seq_q)
        SEQ_IDLE: begin
          if (is_arr) begin
            seq_d = SEQ_ADDR;
            sel_d = blk_bit;
            off_d = wr_off;
          end else if (is_cmd || want_launch) begin
            abort = 1'b1;
          end
        end
        SEQ_ADDR: begin
          if (is_arr) begin
            if (wr_off == off_q) sel_d = sel_q | blk_bit;
            else                 abort = 1'b1;
          end else if (is_cmd) begin
            if (code_ok) seq_d = SEQ_CMD;
            else         abort = 1'b1;
          end else if (want_launch) begin
            abort = 1'b1;
          end
        end
        SEQ_CMD: begin
          if (want_launch)          launch = 1'b1;
          else if (is_arr || is_cmd) abort = 1'b1;
        end
        default: abort = 1'b1;
      endcase
    end
    if (abort || launch) begin
      seq_d = SEQ_IDLE;
      sel_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q     <= SEQ_IDLE;
      sel_q     <= '0;
      off_q     <= '0;
      buf_valid <= 1'b0;
      buf_mask  <= '0;
      acc_err   <= 1'b0;
    end else begin
      seq_q <= seq_d;
      sel_q <= sel_d;
      off_q <= off_d;
      if (launch) begin
        buf_valid <= 1'b1;
        buf_mask  <= sel_q;
      end else if (take) begin
        buf_valid <= 1'b0;
      end
      if (abort)                          acc_err <= 1'b1;
      else if (is_stat && bus_wdata[3])   acc_err <= 1'b0;
    end
  end
endmodule

// File: rtl/bc_scan_engine.sv
module bc_scan_engine
  import blankchk_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int OFF_W     = 5,
  parameter int SETUP_CYC = 4,
  parameter int DONE_CYC  = 10,
  localparam int WORDS    = 1 << OFF_W,
  localparam int TMAX     = (SETUP_CYC > DONE_CYC) ? SETUP_CYC : DONE_CYC,
  localparam int TW       = $clog2(TMAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               buf_valid,
  input  logic [NUM_BLK-1:0] buf_mask,
  input  logic [NUM_BLK-1:0] erased_vec,
  output logic               take,
  output logic [OFF_W-1:0]   scan_off,
  output logic               complete,
  output logic               blank,
  output logic               busy
);
  ex_e                st_q;
  logic [TW-1:0]      tmr_q;
  logic [NUM_BLK-1:0] mask_q;
  logic               pass_q;
  logic               bad_word, last_word;

  assign take      = buf_valid && (st_q == EX_IDLE || (st_q == EX_DONE && tmr_q == '0));
  assign bad_word  = |(mask_q & ~erased_vec);
  assign last_word = (scan_off == OFF_W'(WORDS - 1));
  assign busy      = (st_q != EX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= EX_IDLE;
      tmr_q    <= '0;
      mask_q   <= '0;
      pass_q   <= 1'b0;
      scan_off <= '0;
      complete <= 1'b1;
      blank    <= 1'b0;
    end else begin
      unique case (st_q)
        EX_IDLE: begin
          if (take) begin
            st_q   <= EX_SETUP;
            tmr_q  <= TW'(SETUP_CYC - 2);
            mask_q <= buf_mask;
          end
        end
        EX_SETUP: begin
          if (tmr_q == '0) begin
            st_q     <= EX_SCAN;
            scan_off <= '0;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        EX_SCAN: begin
          if (bad_word) begin
            st_q   <= EX_DONE;
            tmr_q  <= TW'(DONE_CYC - 1);
            pass_q <= 1'b0;
          end else if (last_word) begin
            st_q   <= EX_DONE;
            tmr_q  <= TW'(DONE_CYC - 1);
            pass_q <= 1'b1;
          end else begin
            scan_off <= scan_off + 1'b1;
          end
        end
        EX_DONE: begin
          if (tmr_q == '0) begin
            if (take) begin
              st_q   <= EX_SETUP;
              tmr_q  <= TW'(SETUP_CYC - 2);
              mask_q <= buf_mask;
            end else begin
              st_q     <= EX_IDLE;
              complete <= 1'b1;
              blank    <= pass_q;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: st_q <= EX_IDLE;
      endcase
      // a launch in the same cycle as a completion wins: its command is still pending
      if (launch) begin
        complete <= 1'b0;
        blank    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blankchk_ctrl.sv
module blankchk_ctrl
  import blankchk_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int OFF_W     = 5,
  parameter int DATA_W    = 16,
  parameter int OVH_CYC   = 14,
  parameter int SETUP_CYC = 4,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int AW       = BLK_W + OFF_W,
  localparam int DONE_CYC = OVH_CYC - SETUP_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_space,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [3:0]        stat
);
  logic               buf_valid, take, launch, acc_err;
  logic               complete, blank, eng_busy;
  logic [NUM_BLK-1:0] buf_mask, erased_vec;
  logic [OFF_W-1:0]   scan_off;

  bc_cmd_front #(.NUM_BLK(NUM_BLK), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .take(take),
    .buf_valid(buf_valid), .buf_mask(buf_mask), .launch(launch), .acc_err(acc_err)
  );

  bc_scan_engine #(.NUM_BLK(NUM_BLK), .OFF_W(OFF_W),
                   .SETUP_CYC(SETUP_CYC), .DONE_CYC(DONE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .buf_valid(buf_valid),
    .buf_mask(buf_mask), .erased_vec(erased_vec), .take(take),
    .scan_off(scan_off), .complete(complete), .blank(blank), .busy(eng_busy)
  );

  bc_array_model #(.NUM_BLK(NUM_BLK), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_off(scan_off), .erased_vec(erased_vec)
  );

  always_comb begin
    stat           = '0;
    stat[ST_EMPTY] = !buf_valid;
    stat[ST_DONE]  = complete;
    stat[ST_BLANK] = blank;
    stat[ST_ERR]   = acc_err;
  end
endmodule

// File: rtl/bc_checker.sv
module bc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_space,
  input logic       reg_a0,
  input logic       wd0,
  input logic [3:0] stat,
  input logic       busy
);
  // R2: buffer-empty only falls after a launch write
  p_launch_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(bus_wr && !bus_space && !reg_a0 && wd0));

  // R5: blank is only ever shown together with complete
  p_blank_implies_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |-> stat[1]);

  // R3: complete rises only at the end of a run, with nothing left buffered
  p_done_rise_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> (stat[0] && $past(busy)));

  // R11: blank is cleared only by a launch
  p_clear_on_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[2]) |-> $fell(stat[0]));

  // R9: an access error never coincides with a buffered command
  p_err_no_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[3]) |-> stat[0]);
endmodule

bind blankchk_ctrl bc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_space(bus_space),
  .reg_a0(bus_addr[0]), .wd0(bus_wdata[0]), .stat(stat), .busy(eng_busy)
);

// File: tb/blankchk_ctrl_tb.sv
module blankchk_ctrl_tb;
  localparam int AW = 7;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_space = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [3:0]    stat;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  blankchk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .stat(stat)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [AW-1:0] ad(int b, int o);
    return AW'((b << 5) | o);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic sp, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_space = sp; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ld(int b, int o, logic [DW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = ad(b, o); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // returns the number of edges from the launch edge until complete is seen
  task automatic run(input int b0, input int b1, input int off, output int lat);
    int t0;
    wr(1'b1, ad(b0, off), 16'h1234);
    if (b1 >= 0) wr(1'b1, ad(b1, off), 16'h0000);
    wr(1'b0, 7'd1, 16'h0005);
    wr(1'b0, 7'd0, 16'h0001);
    t0 = cyc;
    while (!stat[1] && cyc - t0 < 400) @(negedge clk);
    lat = cyc - t0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", int'(stat), 3);
  endtask

  task automatic t_full_pass();
    int t0;
    wr(1'b1, ad(1, 7), 16'h0);
    wr(1'b0, 7'd1, 16'h0005);
    wr(1'b0, 7'd0, 16'h0001);
    t0 = cyc;
    chk("R2 buffer-empty after launch", int'(stat[0]), 0);
    chk("R11 complete cleared at launch", int'(stat[1]), 0);
    @(negedge clk);
    chk("R3 buffer-empty after take", int'(stat[0]), 1);
    while (!stat[1] && cyc - t0 < 400) @(negedge clk);
    chk("R4 pass latency", cyc - t0, 46);
    chk("R5 blank after clean pass", int'(stat[2]), 1);
  endtask

  task automatic t_fail_early();
    int lat;
    ld(2, 9, 16'hFFFE);
    wr(1'b1, ad(2, 3), 16'h0);
    wr(1'b0, 7'd1, 16'h0005);
    wr(1'b0, 7'd0, 16'h0001);
    chk("R11 blank cleared at launch", int'(stat[2]), 0);
    lat = 0;
    while (!stat[1] && lat < 400) begin @(negedge clk); lat++; end
    chk("R6 R8 early stop latency", lat, 24);
    chk("R6 blank stays clear", int'(stat[2]), 0);
  endtask

  task automatic t_multi();
    int lat;
    run(0, 3, 20, lat);
    chk("R7 unselected dirty block ignored latency", lat, 46);
    chk("R7 unselected dirty block ignored blank", int'(stat[2]), 1);
    run(0, 2, 5, lat);
    chk("R7 second selected block fails", lat, 24);
    chk("R7 blank clear", int'(stat[2]), 0);
    ld(3, 31, 16'h7FFF);
    run(3, -1, 0, lat);
    chk("R6 last word failure latency", lat, 46);
    chk("R6 last word blank clear", int'(stat[2]), 0);
  endtask

  task automatic seq_err(string tag);
    chk({tag, " access error"}, int'(stat[3]), 1);
    repeat (3) @(negedge clk);
    chk({tag, " no start"}, int'(stat[1:0]), 3);
    wr(1'b0, 7'd0, 16'h0008);
    chk("R10 access error cleared", int'(stat[3]), 0);
  endtask

  task automatic t_seq_err();
    wr(1'b0, 7'd1, 16'h0005);
    seq_err("R9 command without block");
    wr(1'b1, ad(0, 4), 16'h0);
    wr(1'b0, 7'd0, 16'h0001);
    seq_err("R9 launch without command");
    wr(1'b1, ad(0, 4), 16'h0);
    wr(1'b0, 7'd1, 16'h0009);
    seq_err("R9 wrong command code");
    wr(1'b1, ad(0, 4), 16'h0);
    wr(1'b1, ad(1, 6), 16'h0);
    seq_err("R9 mismatched offset");
  endtask

  task automatic t_back_to_back();
    int t0;
    wr(1'b1, ad(1, 2), 16'h0);
    wr(1'b0, 7'd1, 16'h0005);
    wr(1'b0, 7'd0, 16'h0001);
    t0 = cyc;
    wr(1'b1, ad(0, 1), 16'h0);
    wr(1'b0, 7'd1, 16'h0005);
    wr(1'b0, 7'd0, 16'h0001);
    chk("R3 second command buffered", int'(stat[1:0]), 0);
    while (cyc - t0 < 46) @(negedge clk);
    chk("R3 no complete at hand-over", int'(stat[1]), 0);
    chk("R3 buffer freed at hand-over", int'(stat[0]), 1);
    while (!stat[1] && cyc - t0 < 400) @(negedge clk);
    chk("R3 R4 second command end", cyc - t0, 91);
    chk("R5 second command blank", int'(stat[2]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_pass();
    t_fail_early();
    t_multi();
    t_seq_err();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule